// File: doc/BRIEF.md
# Indirect Interrupt Register Router

This block sits between a processor core's indirect register window and one interrupt file. The interrupt file holds one or more pages. Each page has a delivery-enable bit, a priority threshold, a pending-bit array and an enable-bit array. The core presents one access per cycle: a select index, its privilege level, a virtualization flag, a guest-page selector, an access width of 32 or 64 bits, a write value and a per-bit write mask.

The block settles which page the access belongs to and which register it names. It returns the previous register contents and an illegal-access flag combinationally in the same cycle. Any masked update lands on the next rising clock edge. A read is simply an access with an all-zero mask.

The top-interrupt register is reached through a dedicated strobe. The priority search that produces the top identity lives outside this block. The router exports the routed page so that the search engine can feed back its result on `top_id_i`.

Requests carry no back-pressure: every cycle with `req_i` high is accepted and completed in that cycle, so there is no ready signal.

Top module: `ireg_router`

## Requirements
- R1: With `MACHINE_CFG`=1, an access is legal only when `priv_i`=3 (machine) and `virt_i`=0, and it goes to page 0. Every other privilege or virtualization combination raises `illegal_o`.
- R2: With `MACHINE_CFG`=0, `priv_i`=1 (supervisor) with `virt_i`=0 routes to page 0. `priv_i`=1 with `virt_i`=1 routes to page `gsel_i`, which must be nonzero and below `NUM_PAGES`. Any other `priv_i` value is illegal. `page_o` shows the routed page on legal accesses.
- R3: When `top_sel_i`=0, `sel_i` decodes as follows: 0x070 is the delivery bit, 0x072 is the threshold, 0x080–0x0BF are pending-array words and 0x0C0–0x0FF are enable-array words (word number in `sel_i[5:0]`). Every other index is illegal. When `top_sel_i`=1, the access targets the top-interrupt register and `sel_i` is ignored.
- R4: With `wide_i`=1 (64-bit), an odd array word number is illegal. An even one is halved, and the access covers ids 64·(n/2) through 64·(n/2)+63.
- R5: An array word number (after halving) at or above `NUM_IDS/32`, or `NUM_IDS/64` for wide accesses, is illegal.
- R6: Identity 0 of both the pending and the enable array always reads 0, and writes to it have no effect.
- R7: On a legal access, each target bit whose mask bit is 1 takes the matching write-value bit on the next clock edge. Unmasked bits keep their value. `rdata_o` returns the contents before the write, with bit i of an array word being identity (word base + i).
- R8: The delivery register is one bit at `rdata_o[0]`. The threshold is 11 bits at `rdata_o[10:0]`. All wider bits read 0 and ignore writes.
- R9: A top-interrupt read returns `top_id_i` in both `rdata_o[26:16]` and `rdata_o[10:0]`. A top-interrupt access with a nonzero mask and a nonzero in-range `top_id_i` clears that identity's pending bit on the routed page. A zero mask leaves it set.
- R10: An illegal access returns `rdata_o`=0 and changes no state. With `req_i`=0, `illegal_o` and `rdata_o` are 0.
- R11: A 32-bit access (`wide_i`=0) uses only `wmask_i[31:0]` and returns 0 in `rdata_o[63:32]`.
- R12: After reset, every delivery bit, threshold and array bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Access present this cycle |
| top_sel_i | input | 1 | Access targets the top-interrupt register |
| sel_i | input | SEL_W | Indirect select index |
| priv_i | input | 2 | Requesting privilege (0 user, 1 supervisor, 3 machine) |
| virt_i | input | 1 | Access comes from a virtualized context |
| gsel_i | input | GSEL_W | Guest page selector |
| wide_i | input | 1 | 1 for a 64-bit access, 0 for 32-bit |
| wdata_i | input | 64 | Write value |
| wmask_i | input | 64 | Per-bit write mask |
| top_id_i | input | 11 | Top identity from the external search for `page_o` |
| page_o | output | PAGE_W | Routed page |
| rdata_o | output | 64 | Register contents before the access |
| illegal_o | output | 1 | Access rejected |

## Verification
The assertions assume that `top_sel_i` and `sel_i` are stable while `req_i` is high within a cycle, and that `top_id_i` never exceeds the identity range of the instance. They also assume that `NUM_IDS` is a multiple of 64, which makes every legal array word lie fully inside the page. The stimulus draws select indices from a pool that includes the decoded registers, the first array words and near-miss indices. It draws guest selectors from 0 to one past the page count, mostly supervisor privilege, and top identities from within the 64-identity range. As a result, every legal and illegal class is hit without leaving those assumptions.

// File: rtl/ireg_pkg.sv
package ireg_pkg;

  localparam int ID_W    = 11;
  localparam int DATA_W  = 64;

  localparam logic [1:0] PRIV_USER = 2'd0;
  localparam logic [1:0] PRIV_SUP  = 2'd1;
  localparam logic [1:0] PRIV_MACH = 2'd3;

  localparam int SEL_DELIVER = 'h070;
  localparam int SEL_THRESH  = 'h072;

  typedef enum logic [2:0] {
    TGT_NONE,
    TGT_DELIVER,
    TGT_THRESH,
    TGT_TOP,
    TGT_PEND,
    TGT_ENAB
  } tgt_e;

endpackage

// File: rtl/ireg_page_route.sv
module ireg_page_route #(
  parameter bit MACHINE_CFG = 1'b0,
  parameter int NUM_PAGES   = 4,
  parameter int GSEL_W      = 6,
  parameter int PAGE_W      = 2
) (
  input  logic [1:0]        priv_i,
  input  logic              virt_i,
  input  logic [GSEL_W-1:0] gsel_i,
  output logic [PAGE_W-1:0] page_o,
  output logic              ok_o
);
  import ireg_pkg::*;

  generate
    if (MACHINE_CFG) begin : g_mach
      always_comb begin
        page_o = '0;
        ok_o   = (priv_i == PRIV_MACH) && !virt_i;
      end
    end else begin : g_sup
      logic guest_ok;
      assign guest_ok = (gsel_i != '0) && (int'(gsel_i) < NUM_PAGES);
      always_comb begin
        page_o = '0;
        ok_o   = 1'b0;
        if (priv_i == PRIV_SUP) begin
          if (virt_i) begin
            page_o = PAGE_W'(gsel_i);
            ok_o   = guest_ok;
          end else begin
            ok_o = 1'b1;
          end
        end
      end
    end
  endgenerate

endmodule

// File: rtl/ireg_sel_decode.sv
module ireg_sel_decode #(
  parameter int SEL_W   = 12,
  parameter int NUM_IDS = 64
) (
  input  logic             top_sel_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             wide_i,
  output ireg_pkg::tgt_e   tgt_o,
  output logic [5:0]       word_o,
  output logic             ok_o
);
  import ireg_pkg::*;

  localparam int WORDS_NARROW = NUM_IDS / 32;
  localparam int WORDS_WIDE   = NUM_IDS / 64;

  logic [5:0] raw;
  logic       in_array;

  assign raw      = sel_i[5:0];
  assign in_array = (sel_i[SEL_W-1:8] == '0) && sel_i[7];

  always_comb begin
    tgt_o  = TGT_NONE;
    word_o = raw;
    ok_o   = 1'b0;
    if (top_sel_i) begin
      tgt_o = TGT_TOP;
      ok_o  = 1'b1;
    end else if (int'(sel_i) == SEL_DELIVER) begin
      tgt_o = TGT_DELIVER;
      ok_o  = 1'b1;
    end else if (int'(sel_i) == SEL_THRESH) begin
      tgt_o = TGT_THRESH;
      ok_o  = 1'b1;
    end else if (in_array) begin
      tgt_o = sel_i[6] ? TGT_ENAB : TGT_PEND;
      if (wide_i) begin
        word_o = {1'b0, raw[5:1]};
        ok_o   = !raw[0] && (int'(word_o) < WORDS_WIDE);
      end else begin
        ok_o   = int'(raw) < WORDS_NARROW;
      end
    end
  end

endmodule

// File: rtl/ireg_ctl_regs.sv
module ireg_ctl_regs #(
  parameter int NUM_PAGES = 4,
  parameter int PAGE_W    = 2
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         wr_deliver_i,
  input  logic                         wr_thresh_i,
  input  logic [PAGE_W-1:0]            page_i,
  input  logic [ireg_pkg::ID_W-1:0]    wdata_i,
  input  logic [ireg_pkg::ID_W-1:0]    wmask_i,
  output logic                         deliver_o,
  output logic [ireg_pkg::ID_W-1:0]    thresh_o
);
  import ireg_pkg::*;

  logic [NUM_PAGES-1:0]           deliver_q;
  logic [NUM_PAGES-1:0][ID_W-1:0] thresh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      deliver_q <= '0;
      thresh_q  <= '0;
    end else begin
      for (int p = 0; p < NUM_PAGES; p++) begin
        if (int'(page_i) == p) begin
          if (wr_deliver_i && wmask_i[0]) deliver_q[p] <= wdata_i[0];
          if (wr_thresh_i)
            thresh_q[p] <= (thresh_q[p] & ~wmask_i) | (wdata_i & wmask_i);
        end
      end
    end
  end

  always_comb begin
    deliver_o = 1'b0;
    thresh_o  = '0;
    if (int'(page_i) < NUM_PAGES) begin
      deliver_o = deliver_q[page_i];
      thresh_o  = thresh_q[page_i];
    end
  end

endmodule

// File: rtl/ireg_bit_file.sv
module ireg_bit_file #(
  parameter int NUM_PAGES = 4,
  parameter int NUM_IDS   = 64,
  parameter int PAGE_W    = 2
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      wr_en_i,
  input  logic [PAGE_W-1:0]         page_i,
  input  logic [5:0]                word_i,
  input  logic                      wide_i,
  input  logic [63:0]               wdata_i,
  input  logic [63:0]               wmask_i,
  input  logic                      clr_en_i,
  input  logic [ireg_pkg::ID_W-1:0] clr_id_i,
  output logic [63:0]               rdata_o
);
  import ireg_pkg::*;

  logic [NUM_PAGES-1:0][NUM_IDS-1:0] bits_q;
  logic [NUM_PAGES-1:0][NUM_IDS-1:0] bits_d;
  logic [11:0]                       base;
  logic [11:0]                       span;
  logic [NUM_IDS-1:0]                row;
  logic [NUM_IDS-1:0]                shifted;

  assign base = wide_i ? {word_i, 6'b0} : {1'b0, word_i, 5'b0};
  assign span = wide_i ? 12'd64 : 12'd32;

  always_comb begin
    row = '0;
    if (int'(page_i) < NUM_PAGES) row = bits_q[page_i];
    shifted = row >> base;
    rdata_o = wide_i ? shifted[63:0] : {32'b0, shifted[31:0]};
  end

  always_comb begin
    logic [11:0] off;
    bits_d = bits_q;
    for (int p = 0; p < NUM_PAGES; p++) begin
      for (int j = 1; j < NUM_IDS; j++) begin
        off = 12'(j) - base;
        if (wr_en_i && (int'(page_i) == p) && (off < span) && wmask_i[off[5:0]])
          bits_d[p][j] = wdata_i[off[5:0]];
        if (clr_en_i && (int'(page_i) == p) && (int'(clr_id_i) == j))
          bits_d[p][j] = 1'b0;
      end
      bits_d[p][0] = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bits_q <= '0;
    else         bits_q <= bits_d;
  end

endmodule

// File: rtl/ireg_router.sv
module ireg_router #(
  parameter bit MACHINE_CFG = 1'b0,
  parameter int NUM_PAGES   = 4,
  parameter int NUM_IDS     = 64,
  parameter int SEL_W       = 12,
  parameter int GSEL_W      = 6,
  localparam int PAGE_W     = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              top_sel_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [1:0]        priv_i,
  input  logic              virt_i,
  input  logic [GSEL_W-1:0] gsel_i,
  input  logic              wide_i,
  input  logic [63:0]       wdata_i,
  input  logic [63:0]       wmask_i,
  input  logic [10:0]       top_id_i,
  output logic [PAGE_W-1:0] page_o,
  output logic [63:0]       rdata_o,
  output logic              illegal_o
);
  import ireg_pkg::*;

  logic              route_ok;
  logic              sel_ok;
  logic              go;
  tgt_e              tgt;
  logic [5:0]        word;
  logic [PAGE_W-1:0] page;
  logic [63:0]       wmask_eff;
  logic              top_clr;
  logic              deliver_rd;
  logic [ID_W-1:0]   thresh_rd;
  logic [63:0]       pend_rd;
  logic [63:0]       enab_rd;

  ireg_page_route #(
    .MACHINE_CFG(MACHINE_CFG), .NUM_PAGES(NUM_PAGES),
    .GSEL_W(GSEL_W), .PAGE_W(PAGE_W)
  ) u_route (
    .priv_i(priv_i), .virt_i(virt_i), .gsel_i(gsel_i),
    .page_o(page), .ok_o(route_ok)
  );

  ireg_sel_decode #(.SEL_W(SEL_W), .NUM_IDS(NUM_IDS)) u_dec (
    .top_sel_i(top_sel_i), .sel_i(sel_i), .wide_i(wide_i),
    .tgt_o(tgt), .word_o(word), .ok_o(sel_ok)
  );

  assign go        = req_i && route_ok && sel_ok;
  assign wmask_eff = wide_i ? wmask_i : {32'b0, wmask_i[31:0]};
  assign top_clr   = go && (tgt == TGT_TOP) && (wmask_eff != '0) &&
                     (top_id_i != '0) && (int'(top_id_i) < NUM_IDS);

  ireg_ctl_regs #(.NUM_PAGES(NUM_PAGES), .PAGE_W(PAGE_W)) u_ctl (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_deliver_i(go && (tgt == TGT_DELIVER)),
    .wr_thresh_i(go && (tgt == TGT_THRESH)),
    .page_i(page), .wdata_i(wdata_i[ID_W-1:0]), .wmask_i(wmask_eff[ID_W-1:0]),
    .deliver_o(deliver_rd), .thresh_o(thresh_rd)
  );

  ireg_bit_file #(.NUM_PAGES(NUM_PAGES), .NUM_IDS(NUM_IDS), .PAGE_W(PAGE_W)) u_pend (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_en_i(go && (tgt == TGT_PEND)), .page_i(page), .word_i(word),
    .wide_i(wide_i), .wdata_i(wdata_i), .wmask_i(wmask_eff),
    .clr_en_i(top_clr), .clr_id_i(top_id_i), .rdata_o(pend_rd)
  );

  ireg_bit_file #(.NUM_PAGES(NUM_PAGES), .NUM_IDS(NUM_IDS), .PAGE_W(PAGE_W)) u_enab (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_en_i(go && (tgt == TGT_ENAB)), .page_i(page), .word_i(word),
    .wide_i(wide_i), .wdata_i(wdata_i), .wmask_i(wmask_eff),
    .clr_en_i(1'b0), .clr_id_i('0), .rdata_o(enab_rd)
  );

  always_comb begin
    rdata_o = '0;
    if (go) begin
      unique case (tgt)
        TGT_DELIVER: rdata_o = {63'b0, deliver_rd};
        TGT_THRESH:  rdata_o = {53'b0, thresh_rd};
        TGT_TOP:     rdata_o = {37'b0, top_id_i, 5'b0, top_id_i};
        TGT_PEND:    rdata_o = pend_rd;
        TGT_ENAB:    rdata_o = enab_rd;
        default:     rdata_o = '0;
      endcase
    end
  end

  assign page_o    = page;
  assign illegal_o = req_i && !(route_ok && sel_ok);

endmodule

// File: rtl/ireg_router_chk.sv
module ireg_router_chk #(
  parameter bit MACHINE_CFG = 1'b0,
  parameter int NUM_PAGES   = 4,
  parameter int SEL_W       = 12,
  parameter int GSEL_W      = 6,
  parameter int PAGE_W      = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              top_sel_i,
  input logic [SEL_W-1:0]  sel_i,
  input logic [1:0]        priv_i,
  input logic              virt_i,
  input logic [GSEL_W-1:0] gsel_i,
  input logic              wide_i,
  input logic [PAGE_W-1:0] page_o,
  input logic [63:0]       rdata_o,
  input logic              illegal_o
);
  logic is_array;
  logic is_known;
  assign is_array = (int'(sel_i) >= 'h80) && (int'(sel_i) <= 'hFF);
  assign is_known = is_array || (int'(sel_i) == 'h70) || (int'(sel_i) == 'h72);

  assert_mach_route_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (MACHINE_CFG && req_i && !illegal_o) |-> (priv_i == 2'd3 && !virt_i && page_o == '0));

  assert_guest_page_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !illegal_o && virt_i) |-> (int'(page_o) == int'(gsel_i) && gsel_i != '0));

  assert_page_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !illegal_o) |-> (int'(page_o) < NUM_PAGES));

  assert_unknown_sel_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !top_sel_i && !is_known) |-> illegal_o);

  assert_odd_wide_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !top_sel_i && wide_i && is_array && sel_i[0]) |-> illegal_o);

  assert_id_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !illegal_o && !top_sel_i && (int'(sel_i) == 'h80 || int'(sel_i) == 'hC0))
      |-> !rdata_o[0]);

  assert_illegal_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_i || illegal_o) |-> (rdata_o == '0));

  assert_narrow_upper_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !wide_i) |-> (rdata_o[63:32] == '0));

endmodule

bind ireg_router ireg_router_chk #(
  .MACHINE_CFG(MACHINE_CFG), .NUM_PAGES(NUM_PAGES), .SEL_W(SEL_W),
  .GSEL_W(GSEL_W), .PAGE_W(PAGE_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .top_sel_i(top_sel_i),
  .sel_i(sel_i), .priv_i(priv_i), .virt_i(virt_i), .gsel_i(gsel_i),
  .wide_i(wide_i), .page_o(page_o), .rdata_o(rdata_o), .illegal_o(illegal_o)
);

// File: tb/ireg_router_test.sv
module ireg_router_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic        req_m = 1'b0;
  logic        top_sel = 1'b0;
  logic [11:0] sel = '0;
  logic [1:0]  priv = 2'd1;
  logic        virt = 1'b0;
  logic [5:0]  gsel = '0;
  logic        wide = 1'b0;
  logic [63:0] wdata = '0;
  logic [63:0] wmask = '0;
  logic [10:0] top_id = '0;
  logic [1:0]  page;
  logic [63:0] rdata;
  logic        illegal;
  logic [0:0]  page_m;
  logic [63:0] rdata_m;
  logic        illegal_m;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [63:0] m_pend [4];
  logic [63:0] m_enab [4];
  logic        m_del  [4];
  logic [10:0] m_thr  [4];

  always #2 clk = ~clk;

  ireg_router uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .top_sel_i(top_sel), .sel_i(sel),
    .priv_i(priv), .virt_i(virt), .gsel_i(gsel), .wide_i(wide), .wdata_i(wdata),
    .wmask_i(wmask), .top_id_i(top_id), .page_o(page), .rdata_o(rdata),
    .illegal_o(illegal)
  );

  ireg_router #(.MACHINE_CFG(1'b1), .NUM_PAGES(1), .NUM_IDS(128)) uut_m (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req_m), .top_sel_i(top_sel), .sel_i(sel),
    .priv_i(priv), .virt_i(virt), .gsel_i(gsel), .wide_i(wide), .wdata_i(wdata),
    .wmask_i(wmask), .top_id_i(top_id), .page_o(page_m), .rdata_o(rdata_m),
    .illegal_o(illegal_m)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic acc(input bit ts, input logic [11:0] s, input logic [1:0] pv,
                     input bit vt, input logic [5:0] gs, input bit wd,
                     input logic [63:0] wv, input logic [63:0] wm,
                     input logic [10:0] tid, input string tag);
    bit pok, sok, legal;
    int pg, kind, w, span, raw;
    logic [63:0] expv, em;
    @(negedge clk);
    req = 1'b1; top_sel = ts; sel = s; priv = pv; virt = vt; gsel = gs;
    wide = wd; wdata = wv; wmask = wm; top_id = tid;
    #1;
    pok  = (pv == 2'd1) && (!vt || (gs != 0 && gs < 4));
    pg   = vt ? int'(gs) : 0;
    span = wd ? 64 : 32;
    raw  = int'(s[5:0]);
    w = 0; kind = 0; sok = 1'b0;
    if (ts) begin kind = 3; sok = 1'b1; end
    else if (s == 12'h070) begin kind = 1; sok = 1'b1; end
    else if (s == 12'h072) begin kind = 2; sok = 1'b1; end
    else if (s >= 12'h080 && s <= 12'h0FF) begin
      kind = (s >= 12'h0C0) ? 5 : 4;
      if (wd) begin w = raw / 2; sok = (raw % 2 == 0) && (w < 1); end
      else    begin w = raw;     sok = (w < 2); end
    end
    legal = pok && sok;
    em = wd ? wm : {32'b0, wm[31:0]};
    expv = '0;
    if (legal) begin
      case (kind)
        1: expv[0] = m_del[pg];
        2: expv[10:0] = m_thr[pg];
        3: expv = {37'b0, tid, 5'b0, tid};
        4: for (int i = 0; i < span; i++) expv[i] = m_pend[pg][w * span + i];
        5: for (int i = 0; i < span; i++) expv[i] = m_enab[pg][w * span + i];
        default: expv = '0;
      endcase
    end
    chk({tag, " illegal"}, {63'b0, illegal}, {63'b0, !legal});
    chk({tag, " rdata"}, rdata, expv);
    if (legal) chk({tag, " page"}, {62'b0, page}, 64'(pg));
    @(posedge clk);
    if (legal) begin
      case (kind)
        1: if (em[0]) m_del[pg] = wv[0];
        2: m_thr[pg] = (m_thr[pg] & ~em[10:0]) | (wv[10:0] & em[10:0]);
        3: if (em != 0 && tid != 0 && tid < 64) m_pend[pg][tid] = 1'b0;
        4: for (int i = 0; i < span; i++)
             if (em[i] && (w * span + i) != 0) m_pend[pg][w * span + i] = wv[i];
        5: for (int i = 0; i < span; i++)
             if (em[i] && (w * span + i) != 0) m_enab[pg][w * span + i] = wv[i];
        default: ;
      endcase
    end
  endtask

  task automatic acc_m(input logic [1:0] pv, input bit vt, input logic [11:0] s,
                       input bit wd, input bit exp_ill);
    @(negedge clk);
    req = 1'b0; req_m = 1'b1; top_sel = 1'b0; sel = s; priv = pv; virt = vt;
    gsel = 6'd1; wide = wd; wmask = '0;
    #1;
    chk("R1 machine illegal", {63'b0, illegal_m}, {63'b0, exp_ill});
    if (!exp_ill) chk("R1 machine page", {63'b0, page_m}, 64'd0);
    @(posedge clk);
    @(negedge clk);
    req_m = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [11:0] pool [12];
    void'($urandom(32'd1234));
    for (int p = 0; p < 4; p++) begin
      m_pend[p] = '0; m_enab[p] = '0; m_del[p] = 1'b0; m_thr[p] = '0;
    end
    pool = '{12'h070, 12'h072, 12'h080, 12'h081, 12'h082, 12'h083,
             12'h0C0, 12'h0C1, 12'h0C2, 12'h071, 12'h0BF, 12'h100};
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 idle illegal", {63'b0, illegal}, 64'd0);
    chk("R10 idle rdata", rdata, 64'd0);

    // R12 reset state
    acc(0, 12'h070, 1, 0, 0, 0, 0, 0, 0, "R12 deliver");
    acc(0, 12'h072, 1, 0, 0, 0, 0, 0, 0, "R12 thresh");
    acc(0, 12'h080, 1, 0, 0, 1, 0, 0, 0, "R12 pend");
    // R7 masked update, R6 identity zero
    acc(0, 12'h080, 1, 0, 0, 0, 64'hFFFF_FFFF, 64'hF0F0_F00F, 0, "R7 write");
    acc(0, 12'h080, 1, 0, 0, 0, 64'h0, 64'h0000_0F00, 0, "R7 readback");
    acc(0, 12'h0C0, 1, 0, 0, 0, 64'hFFFF_FFFF, 64'hFFFF_FFFF, 0, "R6 enab write");
    acc(0, 12'h0C0, 1, 0, 0, 0, 0, 0, 0, "R6 enab read");
    // R11 upper mask ignored on narrow access
    acc(0, 12'h081, 1, 0, 0, 0, 64'hFFFF_FFFF_0000_0000, 64'hFFFF_FFFF_0000_0000, 0, "R11 narrow");
    acc(0, 12'h081, 1, 0, 0, 0, 0, 0, 0, "R11 word1");
    // R4 / R5
    acc(0, 12'h081, 1, 0, 0, 1, 0, 0, 0, "R4 odd wide");
    acc(0, 12'h080, 1, 0, 0, 1, 64'hA5A5_0000_0000_0000, 64'hFFFF_0000_0000_0000, 0, "R4 wide");
    acc(0, 12'h081, 1, 0, 0, 0, 0, 0, 0, "R4 halved readback");
    acc(0, 12'h082, 1, 0, 0, 1, 0, 0, 0, "R5 wide bound");
    acc(0, 12'h082, 1, 0, 0, 0, 0, 0, 0, "R5 narrow bound");
    // R2 routing
    acc(0, 12'h070, 1, 1, 0, 0, 1, 1, 0, "R2 guest zero");
    acc(0, 12'h070, 1, 1, 4, 0, 1, 1, 0, "R2 guest high");
    acc(0, 12'h070, 1, 1, 3, 0, 1, 1, 0, "R2 guest 3");
    acc(0, 12'h070, 1, 1, 3, 0, 0, 0, 0, "R2 guest 3 read");
    acc(0, 12'h070, 3, 0, 0, 0, 0, 0, 0, "R2 machine priv");
    acc(0, 12'h070, 0, 0, 0, 0, 0, 0, 0, "R2 user priv");
    // R3 decode
    acc(0, 12'h071, 1, 0, 0, 0, 0, 0, 0, "R3 gap");
    acc(0, 12'h100, 1, 0, 0, 0, 0, 0, 0, "R3 above");
    acc(0, 12'h000, 1, 0, 0, 0, 0, 0, 0, "R3 zero");
    acc(1, 12'h100, 1, 0, 0, 0, 0, 0, 11'd9, "R3 top overrides");
    // R8 widths
    acc(0, 12'h070, 1, 0, 0, 0, '1, '1, 0, "R8 deliver");
    acc(0, 12'h070, 1, 0, 0, 0, 0, 0, 0, "R8 deliver read");
    acc(0, 12'h072, 1, 0, 0, 0, '1, '1, 0, "R8 thresh");
    acc(0, 12'h072, 1, 0, 0, 0, 0, 0, 0, "R8 thresh read");
    // R9 top behaviour, pending id 5 on page 2
    acc(0, 12'h080, 1, 1, 2, 0, 64'h20, 64'h20, 0, "R9 set");
    acc(1, 12'h000, 1, 1, 2, 0, 0, 0, 11'd5, "R9 zero mask");
    acc(0, 12'h080, 1, 1, 2, 0, 0, 0, 0, "R9 still set");
    acc(1, 12'h000, 1, 1, 2, 0, 0, 64'h1, 11'd5, "R9 clear");
    acc(0, 12'h080, 1, 1, 2, 0, 0, 0, 0, "R9 cleared");
    // R10 illegal write leaves state
    acc(0, 12'h080, 1, 1, 0, 0, '1, '1, 0, "R10 illegal write");
    acc(0, 12'h080, 1, 0, 0, 0, 0, 0, 0, "R10 page0 intact");
    // R1 machine configuration
    acc_m(2'd3, 1'b0, 12'h070, 1'b0, 1'b0);
    acc_m(2'd3, 1'b1, 12'h070, 1'b0, 1'b1);
    acc_m(2'd1, 1'b0, 12'h070, 1'b0, 1'b1);
    acc_m(2'd3, 1'b0, 12'h083, 1'b0, 1'b0);
    acc_m(2'd3, 1'b0, 12'h084, 1'b0, 1'b1);
    acc_m(2'd3, 1'b0, 12'h082, 1'b1, 1'b0);

    // random mix
    for (int n = 0; n < 600; n++) begin
      logic [1:0] pv;
      pv = ($urandom % 5 == 0) ? 2'($urandom) : 2'd1;
      acc(($urandom % 8) == 0, pool[$urandom % 12], pv, 1'($urandom),
          6'($urandom % 5), 1'($urandom),
          {$urandom, $urandom}, {$urandom, $urandom}, 11'($urandom % 64), "R7 random");
    end

    @(negedge clk);
    req = 1'b0;
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule